// File: doc/BRIEF.md
# MDIO Management Command Controller

This block lets software reach the management registers of an external Ethernet PHY over the two-wire MDC/MDIO bus. Software talks to it through a small register port. It can first load a 16-bit value into the write-data register. It then writes one 16-bit command word, which carries the operation, the PHY address and the PHY register number. The controller turns that command into a complete management frame and clocks it out on MDC. It drives MDIO through an output-enable so the line can be shared with the PHY.

The operation bit that software set stays visible in the command register while the frame runs, and it clears itself when the frame ends. Software polls that bit to learn that the transaction is complete. For a read, the 16 bits returned by the PHY then sit in the read-data register. MDC is made from the system clock by a divider whose half period is a parameter. MDC stays low whenever no frame is running.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command register and the read-data register read 0x0000, and `mdc_o` and `mdio_oe_o` are low.
- R2: The register port uses address 0 for the command register, address 1 for write data and address 2 for read data. In the command word, bit 14 requests a write, bit 13 requests a read, bits 12:8 hold the PHY address and bits 4:0 hold the register number. Reading address 0 returns the stored address and register fields at the same positions, with bits 14 and 13 showing the operation still in progress.
- R3: A write sends 64 bits, most significant first, with `mdio_oe_o` high for all 64. The bits are 32 ones, start pattern 01, opcode 01, the 5 PHY address bits, the 5 register bits, turnaround 10, and then the 16 write-data bits.
- R4: A read sends the same header as a write except that the opcode is 10. `mdio_oe_o` falls from bit 46 through bit 63. The controller samples `mdio_i` on the MDC rising edge of bits 48 to 63, taking the most significant bit first. The 16 sampled bits appear at address 2 when the read bit clears. Address 2 does not change at any other time.
- R5: An accepted operation bit reads as set from the cycle after the command write. It clears exactly 128*MDC_HALF clock cycles after the command write.
- R6: While a frame runs, MDC is high for MDC_HALF cycles and then low for MDC_HALF cycles, with 64 rising edges per frame. MDIO changes only when MDC falls, and MDC stays low while idle.
- R7: A command write that arrives while an operation is in progress is ignored. The stored fields are unchanged and no additional frame is sent.
- R8: A command with both bits 14 and 13 set performs a write. Bit 13 then reads back as 0.
- R9: A command with neither operation bit set stores its address and register fields. It sends no frame and leaves both operation bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select (0 command, 1 write data, 2 read data) |
| reg_wdata_i | input | 16 | Register write value |
| reg_rdata_o | output | 16 | Value of the selected register (combinational) |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe_o | output | 1 | Drive enable for the MDIO pad |
| mdio_i | input | 1 | Management data returned from the pad |

## Verification
The operation bit is due in the cycle after the command-write edge, and the bench checks it at the first falling clock edge after that write. The bit must then clear at the falling edge that follows 128*MDC_HALF rising edges, so the bench counts falling edges until it reads the bit as zero and compares that count with the exact value. Frame content is checked on each rising edge of MDC: a monitor collects the bit and its drive enable, and when 64 bits have arrived it compares them with the item that the driver queued when it issued the command. Read data is checked at address 2 in the first cycle after the busy bit clears.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DW         = 16;
  localparam int AW         = 5;
  localparam int PRE_LEN    = 32;
  localparam int FRAME_LEN  = 64;
  localparam int RD_RELEASE = 46;  // first bit position left undriven in a read
  localparam int DATA_START = 48;
  localparam int WR_BIT     = 14;
  localparam int RD_BIT     = 13;
  localparam int PHY_LSB    = 8;
  localparam int REG_LSB    = 0;
  localparam int IDX_W      = $clog2(FRAME_LEN);

  localparam logic [1:0] ADDR_CMD   = 2'd0;
  localparam logic [1:0] ADDR_WDATA = 2'd1;
  localparam logic [1:0] ADDR_RDATA = 2'd2;

  typedef struct packed {
    logic          wr;
    logic          rd;
    logic [AW-1:0] phy;
    logic [AW-1:0] regn;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [DW-1:0] w);
    cmd_t c;
    c.wr   = w[WR_BIT];
    c.rd   = w[RD_BIT] & ~w[WR_BIT];
    c.phy  = w[PHY_LSB +: AW];
    c.regn = w[REG_LSB +: AW];
    return c;
  endfunction

  function automatic logic [FRAME_LEN-1:0] build_frame(input logic rd, input logic [AW-1:0] phy,
                                                       input logic [AW-1:0] regn,
                                                       input logic [DW-1:0] d);
    return {{PRE_LEN{1'b1}}, 2'b01, (rd ? 2'b10 : 2'b01), phy, regn,
            (rd ? 2'b11 : 2'b10), (rd ? {DW{1'b1}} : d)};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick   = en_i && (cnt_q == CW'(HALF_CYC - 1));
  assign rise_o = tick & ~mdc_q;
  assign fall_o = tick & mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_mdc_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !mdc_o);
  assert_edge_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          is_rd_i,
  input  logic [AW-1:0] phy_i,
  input  logic [AW-1:0] reg_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          mdio_i,
  output logic          active_o,
  output logic          done_o,
  output logic [DW-1:0] cap_o,
  output logic          mdio_o,
  output logic          mdio_oe_o
);
  logic                 active_q, rd_q;
  logic [IDX_W-1:0]     idx_q;
  logic [FRAME_LEN-1:0] sh_q;
  logic [DW-1:0]        cap_q;
  logic                 last;

  assign last      = (idx_q == IDX_W'(FRAME_LEN - 1));
  assign done_o    = active_q & fall_i & last;
  assign active_o  = active_q;
  assign cap_o     = cap_q;
  assign mdio_o    = active_q ? sh_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe_o = active_q && (!rd_q || (idx_q < IDX_W'(RD_RELEASE)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      cap_q    <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        rd_q     <= is_rd_i;
        idx_q    <= '0;
        sh_q     <= build_frame(is_rd_i, phy_i, reg_i, wdata_i);
      end
    end else begin
      if (rise_i && rd_q && (idx_q >= IDX_W'(DATA_START)))
        cap_q <= {cap_q[DW-2:0], mdio_i};
      if (fall_i) begin
        sh_q <= {sh_q[FRAME_LEN-2:0], 1'b0};
        if (last) active_q <= 1'b0;
        else      idx_q    <= idx_q + 1'b1;
      end
    end
  end

  assert_start_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
  assert_mdio_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q) && !$past(fall_i)) |-> $stable(mdio_o));
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          mdc_o,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  input  logic          mdio_i
);
  logic          wr_busy_q, rd_busy_q, busy;
  logic [AW-1:0] phy_q, reg_q;
  logic [DW-1:0] wdata_q, rdata_q, cap;
  logic          cmd_we, accept, start, done, active, rise, fall;
  cmd_t          cmd;
  logic [DW-1:0] cmd_view;

  assign cmd    = decode_cmd(reg_wdata_i);
  assign busy   = wr_busy_q | rd_busy_q;
  assign cmd_we = reg_we_i && (reg_addr_i == ADDR_CMD);
  assign accept = cmd_we && !busy;
  assign start  = accept && (cmd.wr || cmd.rd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_busy_q <= 1'b0;
      rd_busy_q <= 1'b0;
      phy_q     <= '0;
      reg_q     <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
    end else begin
      if (reg_we_i && (reg_addr_i == ADDR_WDATA)) wdata_q <= reg_wdata_i;
      if (accept) begin
        wr_busy_q <= cmd.wr;
        rd_busy_q <= cmd.rd;
        phy_q     <= cmd.phy;
        reg_q     <= cmd.regn;
      end else if (done) begin
        wr_busy_q <= 1'b0;
        rd_busy_q <= 1'b0;
        if (rd_busy_q) rdata_q <= cap;
      end
    end
  end

  always_comb begin
    cmd_view                 = '0;
    cmd_view[WR_BIT]         = wr_busy_q;
    cmd_view[RD_BIT]         = rd_busy_q;
    cmd_view[PHY_LSB +: AW]  = phy_q;
    cmd_view[REG_LSB +: AW]  = reg_q;
    case (reg_addr_i)
      ADDR_CMD:   reg_rdata_o = cmd_view;
      ADDR_WDATA: reg_rdata_o = wdata_q;
      ADDR_RDATA: reg_rdata_o = rdata_q;
      default:    reg_rdata_o = '0;
    endcase
  end

  mdio_clk_div #(.HALF_CYC(MDC_HALF)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (active),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_eng i_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .is_rd_i   (cmd.rd),
    .phy_i     (cmd.phy),
    .reg_i     (cmd.regn),
    .wdata_i   (wdata_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .active_o  (active),
    .done_o    (done),
    .cap_o     (cap),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  assert_one_op_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_busy_q && rd_busy_q));
  assert_done_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !busy);
  assert_ignore_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_we && !done) |=> $stable(phy_q) && $stable(reg_q) && busy);
  assert_rdata_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done && rd_busy_q) |=> $stable(rdata_q));
  assert_busy_tracks_engine_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> active);
endmodule

// File: tb/test_mdio_cmd_ctrl.sv
module test_mdio_cmd_ctrl;
  localparam int HALF = 2;
  localparam int FRAME_CYC = 128 * HALF;

  typedef struct {
    logic [63:0] frame;
    logic [63:0] mask;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        mdc, mdio_out, mdio_oe, mdio_in;
  logic [15:0] phy_val = '0;
  logic [5:0]  bc = '0;
  logic [63:0] obs = '0, msk = '0;
  exp_t        sb_q[$];
  int          n_cmp = 0, n_bad = 0, mon_cmp = 0, mon_bad = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  mdio_cmd_ctrl #(.MDC_HALF(HALF)) i_mdio_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  // PHY model: returns phy_val in bits 48..63 of the frame
  assign mdio_in = (bc >= 6'd48) ? phy_val[15 - (int'(bc) - 48)] : 1'b1;

  // monitor: collects 64 MDC bits and compares against the scoreboard
  always @(posedge mdc) begin
    exp_t e;
    obs = {obs[62:0], mdio_out};
    msk = {msk[62:0], mdio_oe};
    bc  = bc + 1'b1;
    if (bc == 6'd0) begin
      mon_cmp++;
      if (sb_q.size() == 0) begin
        mon_bad++;
        $display("FAIL R7 unexpected frame act=%h exp=none", obs);
      end else begin
        e = sb_q.pop_front();
        if (msk != e.mask || (obs & e.mask) != (e.frame & e.mask)) begin
          mon_bad++;
          $display("FAIL R3/R4 frame act=%h/%h exp=%h/%h", obs, msk, e.frame, e.mask);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + mon_cmp, n_bad + mon_bad);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 2'd0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
    addr = 2'd0;
  endtask

  // driver: queue the expected frame, issue the command, time completion
  task automatic run(input logic [15:0] cmd, input logic [15:0] wd, input logic [15:0] pv,
                     input bit inject, input string req);
    exp_t        e;
    logic        is_wr, is_rd;
    logic [15:0] view, v;
    int          k, hi, bad_hi, rises;
    bit          prev;
    is_wr = cmd[14];
    is_rd = !cmd[14] && cmd[13];
    e.frame = {32'hFFFF_FFFF, 2'b01, (is_rd ? 2'b10 : 2'b01), cmd[12:8], cmd[4:0],
               2'b10, wd};
    e.mask  = is_rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    sb_q.push_back(e);
    phy_val = pv;
    reg_wr(2'd1, wd);
    reg_wr(2'd0, cmd);
    view = {1'b0, is_wr, is_rd, cmd[12:8], 3'b000, cmd[4:0]};
    reg_rd(2'd0, v);
    check(v == view, {req, " R2 R5 busy readback"}, v, view);
    k = 1; hi = 0; bad_hi = 0; rises = 0; prev = 1'b0;
    while (v[14] || v[13]) begin
      if (inject && k == 40) begin we = 1'b1; addr = 2'd0; wdata = 16'h2A1F; end
      if (inject && k == 41) begin we = 1'b0; end
      if (inject && k == 45) begin
        reg_rd(2'd0, v);
        check(v == view, "R7 fields unchanged while busy", v, view);
      end
      if (mdc) hi++;
      else if (hi != 0) begin
        if (hi != HALF) bad_hi++;
        hi = 0;
      end
      if (mdc && !prev) rises++;
      prev = mdc;
      @(negedge clk);
      k++;
      reg_rd(2'd0, v);
      if (k > 4 * FRAME_CYC) break;
    end
    check(k - 1 == FRAME_CYC, {req, " R5 op bit clear time"}, k - 1, FRAME_CYC);
    check(bad_hi == 0 && rises == 64, {req, " R6 MDC shape"}, rises, 64);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R6 idle after frame", {mdc, mdio_oe}, 0);
  endtask

  initial begin
    logic [15:0] v;
    int rises;
    repeat (3) @(negedge clk);
    reg_rd(2'd0, v); check(v == 16'h0000, "R1 cmd reset", v, 0);
    reg_rd(2'd2, v); check(v == 16'h0000, "R1 rdata reset", v, 0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins reset", {mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(16'h4104, 16'h01E1, 16'h0000, 1'b0, "R3 write");
    reg_rd(2'd1, v); check(v == 16'h01E1, "R2 write-data readback", v, 16'h01E1);
    run(16'h2201, 16'h0000, 16'h782D, 1'b0, "R4 read");
    reg_rd(2'd2, v); check(v == 16'h782D, "R4 read data", v, 16'h782D);
    run(16'h3F1F, 16'h0000, 16'h8001, 1'b0, "R4 read max fields");
    reg_rd(2'd2, v); check(v == 16'h8001, "R4 read data edges", v, 16'h8001);
    run(16'h4000, 16'hFFFF, 16'h1234, 1'b0, "R3 write zero fields");
    reg_rd(2'd2, v); check(v == 16'h8001, "R4 read data held across write", v, 16'h8001);
    run(16'h6A0C, 16'hA5C3, 16'h0000, 1'b0, "R8 both bits");
    run(16'h4513, 16'h5A5A, 16'h0000, 1'b1, "R7 busy write");

    reg_wr(2'd0, 16'h0305);
    reg_rd(2'd0, v); check(v == 16'h0305, "R9 fields stored no op", v, 16'h0305);
    rises = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (mdc) rises++;
    end
    check(rises == 0, "R9 no MDC activity", rises, 0);
    reg_rd(2'd0, v); check(v[14:13] == 2'b00, "R9 op bits clear", v, 16'h0305);

    repeat (20) @(negedge clk);
    check(sb_q.size() == 0, "R7 scoreboard drained", sb_q.size(), 0);
    check(mon_cmp == 6, "R3 R4 frame count", mon_cmp, 6);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      summary();
      $finish;
    end
  end
endmodule